// File: doc/BRIEF.md
# Transceiver Operation Mode Controller

This block tracks the operating mode of a ULPI USB 2.0 transceiver. It watches the reset and chip-select pins, both passed through synchronizers. It also watches a core power-on reset, strobes that mark link writes to the suspend and carkit-pass-through register bits, and the ULPI stop line. From these it selects one of six modes: Normal, Configuration, Low Power, Sleep, UART Pass Through and Tri-state Output.

Every change driven by the pins is accepted only after the pin levels have stayed unchanged for a programmable qualification time. Register-driven modes are entered only from Normal. A request that leads from one non-Normal mode to another always passes through Normal for at least one cycle. Low Power stops the PHY clock for a minimum number of cycles. It ends with a wake sequence driven by the stop line. The outputs are the mode code, a ULPI output enable, a PHY clock enable, a DIR request, a one-cycle strobe on every mode change and a strobe that sets the suspend bit again. A parameter removes the Tri-state mode for the smaller package variant.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While `por_n` is low and right after it rises, the mode is Configuration. Mode codes are Normal=0, Configuration=1, Low Power=2, Sleep=3, UART Pass Through=4, Tri-state=5. In this state `ulpi_oe`=0, `clk_en`=1 and `dir_req`=0.
- R2: In Configuration, reset pin high together with chip select low, held for TSTATE cycles, moves the mode to Normal. In Normal `ulpi_oe`=1.
- R3: A pin pattern that changes again before TSTATE cycles have passed is ignored. The qualification count restarts on every change of the pins.
- R4: In Normal, reset pin low with chip select low, held for TSTATE cycles, enters Sleep. In Sleep `ulpi_oe`=0 and `clk_en`=0. Raising the reset pin (chip select low) and holding it returns the mode to Normal.
- R5: In Normal, reset pin low with chip select high, held for TSTATE cycles, enters Configuration.
- R6: With HAS_TRISTATE=1, both pins high and held for TSTATE cycles enter Tri-state, where `ulpi_oe`=0. Chip select low returns the mode to Normal. With HAS_TRISTATE=0 the same pattern leaves the block in Normal.
- R7: A suspend-clear write strobe in Normal enters Low Power with `clk_en`=0 and `dir_req`=1. The same strobe in any other mode has no effect.
- R8: After Low Power is entered, `clk_en` stays 0 for at least MIN_STOP cycles, even when the stop line is already high.
- R9: A high stop line after the minimum stop wakes the block. `clk_en` returns to 1 while `dir_req` stays 1 for WAKE_CYC cycles. Then the mode becomes Normal, `dir_req` falls and `suspendm_set` pulses high for exactly that cycle.
- R10: A carkit-set write strobe in Normal enters UART Pass Through, with `ulpi_oe`=1. A carkit-clear strobe returns the mode to Normal. A carkit-set strobe outside Normal has no effect.
- R11: A move from one non-Normal mode to a different non-Normal mode always shows Normal for at least one cycle in between.
- R12: `mode_chg` is high for exactly the cycles in which `mode` differs from its value in the previous cycle, including each pass through Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| por_n | input | 1 | Core power-on reset, active low, asynchronous |
| rstn_pin | input | 1 | Reset pin, asynchronous to clk |
| csn_pin | input | 1 | Chip select pin, asynchronous to clk |
| suspend_clr_wr | input | 1 | One-cycle strobe: link wrote the suspend bit to 0 |
| carkit_set_wr | input | 1 | One-cycle strobe: link wrote the carkit pass-through bit to 1 |
| carkit_clr_wr | input | 1 | One-cycle strobe: link wrote the carkit pass-through bit to 0 |
| stp | input | 1 | ULPI stop line, asynchronous wake request |
| mode | output | 3 | Current mode code |
| mode_chg | output | 1 | One-cycle strobe on every mode change |
| ulpi_oe | output | 1 | Enable for the ULPI output drivers |
| clk_en | output | 1 | PHY clock gate enable |
| dir_req | output | 1 | Request for ULPI DIR high (PHY owns the bus) |
| suspendm_set | output | 1 | One-cycle strobe that sets the suspend bit back to 1 |

## Verification
The assertions check on every cycle the rules between one cycle and the next. Normal must separate two different non-Normal modes. Low Power and Pass Through may be entered only from Normal. The clock must stay stopped for the minimum time, DIR must fall together with the suspend strobe, the change strobe must match the mode changes, and the variant without Tri-state must never show it. The bench scenarios cover the rest. They show that the pin filter rejects short patterns, which pin pattern leads to which mode, that writes outside Normal are ignored, the wake timing, and the exact order of modes on a route such as Low Power to Sleep through Normal.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;
   typedef enum logic [2:0] {
      MD_NORMAL   = 3'd0,
      MD_CONFIG   = 3'd1,
      MD_LOWPWR   = 3'd2,
      MD_SLEEP    = 3'd3,
      MD_PASSTHRU = 3'd4,
      MD_TRISTATE = 3'd5
   } mode_e;
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xcvr_sync needs at least two stages");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/xcvr_pin_qual.sv
module xcvr_pin_qual
   import xcvr_mode_pkg::*;
#(
   parameter int unsigned TSTATE       = 16,
   parameter bit          HAS_TRISTATE = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  rstn_s,
   input  logic  csn_s,
   output mode_e tgt
);
   localparam int unsigned CW = (TSTATE > 1) ? $clog2(TSTATE) : 1;
   localparam logic [CW-1:0] CMAX = CW'(TSTATE - 1);

   mode_e          code, cand;
   logic  [CW-1:0] cnt;

   // pin pattern -> requested mode; variant decides the both-high case
   if (HAS_TRISTATE) begin : g_tri
      always_comb begin
         unique case ({rstn_s, csn_s})
            2'b00:   code = MD_SLEEP;
            2'b01:   code = MD_CONFIG;
            2'b10:   code = MD_NORMAL;
            default: code = MD_TRISTATE;
         endcase
      end
   end else begin : g_no_tri
      always_comb begin
         unique case ({rstn_s, csn_s})
            2'b00:   code = MD_SLEEP;
            2'b01:   code = MD_CONFIG;
            default: code = MD_NORMAL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand <= MD_CONFIG;
         cnt  <= '0;
         tgt  <= MD_CONFIG;
      end else if (code != cand) begin
         cand <= code;
         cnt  <= '0;
      end else if (cnt == CMAX) begin
         tgt  <= cand;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/xcvr_lp_seq.sv
module xcvr_lp_seq #(
   parameter int unsigned MIN_STOP = 5,
   parameter int unsigned WAKE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic stp_s,
   output logic clk_stop,
   output logic wake_done
);
   localparam int unsigned SW = $clog2(MIN_STOP + 1);
   localparam int unsigned WW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
   localparam logic [SW-1:0] SMAX = SW'(MIN_STOP);
   localparam logic [WW-1:0] WMAX = WW'(WAKE_CYC - 1);

   logic [SW-1:0] stop_cnt;
   logic [WW-1:0] wk_cnt;
   logic          waking;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_cnt <= '0;
         wk_cnt   <= '0;
         waking   <= 1'b0;
      end else if (!active) begin
         stop_cnt <= '0;
         wk_cnt   <= '0;
         waking   <= 1'b0;
      end else begin
         if (stop_cnt != SMAX) stop_cnt <= stop_cnt + 1'b1;
         if (!waking && stop_cnt == SMAX && stp_s) waking <= 1'b1;
         if (waking && wk_cnt != WMAX) wk_cnt <= wk_cnt + 1'b1;
      end
   end

   assign clk_stop  = active && !waking;
   assign wake_done = waking && (wk_cnt == WMAX);
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
   import xcvr_mode_pkg::*;
#(
   parameter int unsigned TSTATE       = 16,
   parameter int unsigned MIN_STOP     = 5,
   parameter int unsigned WAKE_CYC     = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          HAS_TRISTATE = 1'b1
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       rstn_pin,
   input  logic       csn_pin,
   input  logic       suspend_clr_wr,
   input  logic       carkit_set_wr,
   input  logic       carkit_clr_wr,
   input  logic       stp,
   output logic [2:0] mode,
   output logic       mode_chg,
   output logic       ulpi_oe,
   output logic       clk_en,
   output logic       dir_req,
   output logic       suspendm_set
);
   if (TSTATE < 2) begin : g_bad_tstate
      $error("TSTATE must be at least 2");
   end
   if (MIN_STOP < 1 || WAKE_CYC < 1) begin : g_bad_lp
      $error("MIN_STOP and WAKE_CYC must be at least 1");
   end

   logic [1:0] pins_s;
   logic       stp_s, lp_stop, wake_done;
   mode_e      tgt, cur, nxt;

   // {csn, rstn}: reset value matches the power-on Configuration pattern
   xcvr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_pin_sync (
      .clk(clk), .rst_n(por_n), .d({csn_pin, rstn_pin}), .q(pins_s));

   xcvr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stp_sync (
      .clk(clk), .rst_n(por_n), .d(stp), .q(stp_s));

   xcvr_pin_qual #(.TSTATE(TSTATE), .HAS_TRISTATE(HAS_TRISTATE)) u_qual (
      .clk(clk), .rst_n(por_n), .rstn_s(pins_s[0]), .csn_s(pins_s[1]), .tgt(tgt));

   xcvr_lp_seq #(.MIN_STOP(MIN_STOP), .WAKE_CYC(WAKE_CYC)) u_lp (
      .clk(clk), .rst_n(por_n), .active(cur == MD_LOWPWR), .stp_s(stp_s),
      .clk_stop(lp_stop), .wake_done(wake_done));

   // a qualified pin target persists while the pins stay put, so it also
   // serves as the pending request after the mandatory stop in Normal
   always_comb begin
      nxt = cur;
      unique case (cur)
         MD_NORMAL: begin
            if (tgt != MD_NORMAL)    nxt = tgt;
            else if (suspend_clr_wr) nxt = MD_LOWPWR;
            else if (carkit_set_wr)  nxt = MD_PASSTHRU;
         end
         MD_CONFIG, MD_SLEEP, MD_TRISTATE: begin
            if (tgt != cur) nxt = MD_NORMAL;
         end
         MD_LOWPWR: begin
            if (tgt != MD_NORMAL || wake_done) nxt = MD_NORMAL;
         end
         MD_PASSTHRU: begin
            if (tgt != MD_NORMAL || carkit_clr_wr) nxt = MD_NORMAL;
         end
         default: nxt = MD_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cur          <= MD_CONFIG;
         mode_chg     <= 1'b0;
         suspendm_set <= 1'b0;
      end else begin
         cur          <= nxt;
         mode_chg     <= (nxt != cur);
         suspendm_set <= (cur == MD_LOWPWR) && (nxt != MD_LOWPWR);
      end
   end

   assign mode    = cur;
   assign ulpi_oe = (cur == MD_NORMAL) || (cur == MD_LOWPWR) || (cur == MD_PASSTHRU);
   assign clk_en  = (cur != MD_SLEEP) && !lp_stop;
   assign dir_req = (cur == MD_LOWPWR);
endmodule

// File: rtl/xcvr_mode_chk.sv
module xcvr_mode_chk
   import xcvr_mode_pkg::*;
#(
   parameter int unsigned MIN_STOP     = 5,
   parameter bit          HAS_TRISTATE = 1'b1
) (
   input logic       clk,
   input logic       por_n,
   input logic [2:0] mode,
   input logic       mode_chg,
   input logic       ulpi_oe,
   input logic       clk_en,
   input logic       dir_req,
   input logic       suspendm_set
);
   localparam int unsigned SW = $clog2(MIN_STOP + 1);
   logic [SW-1:0] stop_run;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                        stop_run <= '0;
      else if (clk_en)                   stop_run <= '0;
      else if (stop_run != SW'(MIN_STOP)) stop_run <= stop_run + 1'b1;
   end

   a_r11_via_normal: assert property (@(posedge clk) disable iff (!por_n)
      (mode != MD_NORMAL) |=> (mode == $past(mode) || mode == MD_NORMAL));

   a_r7_lowpwr_from_normal: assert property (@(posedge clk) disable iff (!por_n)
      (mode == MD_LOWPWR && $past(mode) != MD_LOWPWR) |-> $past(mode) == MD_NORMAL);

   a_r10_passthru_from_normal: assert property (@(posedge clk) disable iff (!por_n)
      (mode == MD_PASSTHRU && $past(mode) != MD_PASSTHRU) |-> $past(mode) == MD_NORMAL);

   a_r8_min_stop: assert property (@(posedge clk) disable iff (!por_n)
      (mode == MD_LOWPWR && $past(mode) == MD_LOWPWR && $rose(clk_en))
      |-> stop_run == SW'(MIN_STOP));

   a_r12_strobe_on_change: assert property (@(posedge clk) disable iff (!por_n)
      (mode != $past(mode)) |-> mode_chg);

   a_r12_strobe_only_on_change: assert property (@(posedge clk) disable iff (!por_n)
      mode_chg |-> (mode != $past(mode)));

   a_r9_dir_release: assert property (@(posedge clk) disable iff (!por_n)
      $fell(dir_req) |-> (suspendm_set && mode == MD_NORMAL));

   a_r4_sleep_quiet: assert property (@(posedge clk) disable iff (!por_n)
      (mode == MD_SLEEP) |-> (!ulpi_oe && !clk_en));

   a_r6_variant_mode: assert property (@(posedge clk) disable iff (!por_n)
      (mode == MD_TRISTATE) |-> (HAS_TRISTATE && !ulpi_oe));
endmodule

bind xcvr_mode_ctrl xcvr_mode_chk #(.MIN_STOP(MIN_STOP), .HAS_TRISTATE(HAS_TRISTATE)) u_chk (
   .clk(clk), .por_n(por_n), .mode(mode), .mode_chg(mode_chg), .ulpi_oe(ulpi_oe),
   .clk_en(clk_en), .dir_req(dir_req), .suspendm_set(suspendm_set));

// File: tb/tb_xcvr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_xcvr_mode_ctrl;
   localparam int TS   = 8;
   localparam int MSTP = 5;
   localparam int WK   = 4;
   localparam int SETTLE = 30;

   logic clk = 1'b0;
   logic por_n, rstn_pin, csn_pin, susp_clr, ck_set, ck_clr, stp;
   logic [2:0] mode, mode_nt;
   logic mode_chg, ulpi_oe, clk_en, dir_req, sus_set;
   logic chg_nt, oe_nt, ce_nt, dir_nt, ss_nt;

   int errs = 0, checks = 0;
   int hist[64];
   int hn = 0;
   int strobe_bad = 0;
   logic [2:0] prev_mode = 3'd1;

   always #2.5 clk = ~clk;

   xcvr_mode_ctrl #(.TSTATE(TS), .MIN_STOP(MSTP), .WAKE_CYC(WK), .HAS_TRISTATE(1'b1)) dut (
      .clk(clk), .por_n(por_n), .rstn_pin(rstn_pin), .csn_pin(csn_pin),
      .suspend_clr_wr(susp_clr), .carkit_set_wr(ck_set), .carkit_clr_wr(ck_clr), .stp(stp),
      .mode(mode), .mode_chg(mode_chg), .ulpi_oe(ulpi_oe), .clk_en(clk_en),
      .dir_req(dir_req), .suspendm_set(sus_set));

   xcvr_mode_ctrl #(.TSTATE(TS), .MIN_STOP(MSTP), .WAKE_CYC(WK), .HAS_TRISTATE(1'b0)) dut_nt (
      .clk(clk), .por_n(por_n), .rstn_pin(rstn_pin), .csn_pin(csn_pin),
      .suspend_clr_wr(susp_clr), .carkit_set_wr(ck_set), .carkit_clr_wr(ck_clr), .stp(stp),
      .mode(mode_nt), .mode_chg(chg_nt), .ulpi_oe(oe_nt), .clk_en(ce_nt),
      .dir_req(dir_nt), .suspendm_set(ss_nt));

   // mode history and strobe consistency, sampled away from the active edge
   always @(negedge clk) begin
      if (por_n) begin
         if (mode_chg && hn < 64) begin hist[hn] = int'(mode); hn++; end
         if ((mode != prev_mode) != mode_chg) strobe_bad++;
         prev_mode = mode;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1; tick(1); s = 1'b0;
   endtask

   initial begin
      #(5.0 * 100000);
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int base, cnt;
      por_n = 1'b0; rstn_pin = 1'b0; csn_pin = 1'b1;
      susp_clr = 1'b0; ck_set = 1'b0; ck_clr = 1'b0; stp = 1'b0;
      tick(3);
      // R1 reset state
      chk(mode == 3'd1, "R1 mode in reset", mode, 1);
      chk(!ulpi_oe && clk_en && !dir_req, "R1 outputs in reset",
          {ulpi_oe, clk_en, dir_req}, 3'b010);
      por_n = 1'b1;
      tick(1);
      chk(mode == 3'd1, "R1 mode after reset", mode, 1);

      // R3 short pulse of the Normal pattern is ignored
      rstn_pin = 1'b1; csn_pin = 1'b0; tick(3);
      rstn_pin = 1'b0; csn_pin = 1'b1; tick(SETTLE);
      chk(mode == 3'd1, "R3 short pin pulse ignored", mode, 1);
      // R7 / R10 writes outside Normal ignored
      pulse(susp_clr); tick(2);
      chk(mode == 3'd1, "R7 suspend write outside Normal", mode, 1);
      pulse(ck_set); tick(2);
      chk(mode == 3'd1, "R10 carkit write outside Normal", mode, 1);

      // R2 Configuration -> Normal
      rstn_pin = 1'b1; csn_pin = 1'b0; tick(TS / 2);
      chk(mode == 3'd1, "R3 before qualification time", mode, 1);
      tick(SETTLE);
      chk(mode == 3'd0 && ulpi_oe, "R2 Normal after config exit", mode, 0);

      // R6 Tri-state and the variant without it
      csn_pin = 1'b1; tick(SETTLE);
      chk(mode == 3'd5 && !ulpi_oe, "R6 tri-state entered", mode, 5);
      chk(mode_nt == 3'd0 && oe_nt, "R6 variant stays Normal", mode_nt, 0);
      csn_pin = 1'b0; tick(SETTLE);
      chk(mode == 3'd0, "R6 tri-state exit", mode, 0);

      // R7 / R8 / R9 Low Power with early STP
      pulse(susp_clr);
      chk(mode == 3'd2 && !clk_en && dir_req, "R7 Low Power entered", mode, 2);
      stp = 1'b1;
      cnt = 0;
      while (!clk_en && cnt < 100) begin cnt++; tick(1); end
      chk(cnt >= MSTP && cnt <= MSTP + 4, "R8 clock stop length", cnt, MSTP + 1);
      chk(mode == 3'd2 && dir_req, "R9 DIR held during wake", mode, 2);
      cnt = 0;
      while (mode == 3'd2 && cnt < 100) begin cnt++; tick(1); end
      chk(cnt == WK, "R9 wake duration", cnt, WK);
      chk(mode == 3'd0 && !dir_req && sus_set, "R9 Normal with suspend set",
          {mode, dir_req, sus_set}, 5'b00001);
      tick(1);
      chk(!sus_set, "R9 suspend strobe one cycle", sus_set, 0);
      stp = 1'b0; tick(4);

      // R11 Low Power -> Sleep passes Normal; R10 carkit write in Low Power ignored
      pulse(susp_clr); tick(1);
      pulse(ck_set); tick(2);
      chk(mode == 3'd2, "R10 carkit write in Low Power", mode, 2);
      base = hn;
      rstn_pin = 1'b0; tick(SETTLE);
      chk(hn - base == 2, "R11 change count LP to Sleep", hn - base, 2);
      chk(hist[base] == 0 && hist[base + 1] == 3, "R11 order LP->Normal->Sleep",
          hist[base] * 10 + hist[base + 1], 3);
      chk(mode == 3'd3 && !ulpi_oe && !clk_en && !dir_req, "R4 Sleep outputs", mode, 3);
      rstn_pin = 1'b1; tick(SETTLE);
      chk(mode == 3'd0, "R4 Sleep exit", mode, 0);

      // R10 Pass Through, R7 suspend write ignored there
      pulse(ck_set);
      chk(mode == 3'd4 && ulpi_oe, "R10 Pass Through entered", mode, 4);
      pulse(susp_clr); tick(2);
      chk(mode == 3'd4 && clk_en, "R7 suspend write in Pass Through", mode, 4);
      pulse(ck_clr);
      chk(mode == 3'd0, "R10 Pass Through exit", mode, 0);

      // R5 Normal -> Configuration, then R11 Configuration -> Tri-state via Normal
      rstn_pin = 1'b0; csn_pin = 1'b1; tick(SETTLE);
      chk(mode == 3'd1 && !ulpi_oe, "R5 Configuration entered", mode, 1);
      base = hn;
      rstn_pin = 1'b1; tick(SETTLE);
      chk(hn - base == 2 && hist[base] == 0 && hist[base + 1] == 5,
          "R11 order Config->Normal->Tri", hist[base] * 10 + hist[base + 1], 5);
      chk(mode_nt == 3'd0, "R6 variant leaves config to Normal", mode_nt, 0);
      csn_pin = 1'b0; tick(SETTLE);
      chk(mode == 3'd0, "R6 back to Normal", mode, 0);

      chk(strobe_bad == 0, "R12 strobe matches mode changes", strobe_bad, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule